// File: doc/BRIEF.md
# Two-Wire Register Slave for a Sixteen-Pin GPIO and LED Controller

This block is the digital front end of a sixteen-pin pin controller. Each pin can act as a GPIO or as a dimmed LED driver. A host reaches it over an I2C bus. The block samples SCL and SDA with its own system clock and recognises START, repeated START and STOP. It answers only its own 7-bit address and keeps a register pointer that the host sets with the first byte of a write.

Configuration leaves the block as plain outputs:
- output levels
- pin directions
- interrupt masks
- port-0 drive style and dimming range
- per-pin LED/GPIO mode
- sixteen 8-bit dimming levels

The live pin levels come in and can be read back. Two single-cycle strobes tell the interrupt logic outside when an input register has been fetched for a read.

Two strap inputs set the low two address bits. They also set the reset value of the output registers. A write of 00h to a dedicated register returns every register to its default and emits a one-cycle software-reset pulse.

Top module: `pinctl_i2c_slave`

## Requirements
- R1: The block acknowledges only the 7-bit address {1,0,1,1,0,strap_i[1],strap_i[0]}. It leaves SDA released on any other address, including the all-zero general call, and a transfer to another address changes no register.
- R2: In a write transfer, the first byte after the address loads the register pointer. Each following data byte is written to the pointer, and the pointer then advances by one, wrapping from FFh to 00h.
- R3: After a pointer write, a repeated START and the address with R/W=1 make the block send the register at the pointer, MSB first. Each byte the host acknowledges is followed by the next address. A NACK ends the read and leaves SDA released.
- R4: Register 00h reads pin_lvl_i[7:0] and 01h reads pin_lvl_i[15:8], whatever the pin direction. Writes to them have no effect.
- R5: Registers 02h/03h drive out_val_o[7:0]/[15:8] and read back the stored value. Within one clock of reset release, and on every software reset, each port takes 4'hF in bits 3:0 if strap_i[0] is high and 4'hF in bits 7:4 if strap_i[1] is high, and zeros elsewhere.
- R6: Registers 04h/05h drive dir_in_o (1 = input) and 06h/07h drive irq_mask_o (1 = interrupt disabled). All four reset to 00h and read back.
- R7: Register 10h always reads 23h, and writes to it are ignored.
- R8: In register 11h, bit 4 drives p0_push_pull_o (1 = push-pull) and bits 1:0 drive dim_range_o (0 = full, 1 = 3/4, 2 = 2/4, 3 = 1/4). Its other bits read 0, and it resets to 00h.
- R9: Registers 12h/13h drive led_gpio_o[7:0]/[15:8] (1 = GPIO, 0 = LED), reset to FFh and read back.
- R10: A write to 20h+k (k = 0..15) sets the level of pin 8+k for k<4, pin k-4 for 4≤k<12 and pin k for k≥12. Pin n's level sits in dim_lvl_o[8n+7:8n]. The levels reset to 00h, and reading 20h–2Fh, 7Fh or an unmapped address returns 00h.
- R11: Writing 00h to 7Fh pulses soft_rst_o for one cycle, and in that cycle every register is at its default (R5 using the current straps). Any other value written to 7Fh has no effect.
- R12: rd_in0_o / rd_in1_o pulse for one cycle each time register 00h / 01h is loaded for transmission. They are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| strap_i | input | 2 | Address straps {bit1, bit0}, also select output defaults |
| pin_lvl_i | input | 16 | Live pin levels, port 1 in [15:8] |
| out_val_o | output | 16 | Output levels |
| dir_in_o | output | 16 | 1 = pin is input |
| irq_mask_o | output | 16 | 1 = interrupt disabled |
| led_gpio_o | output | 16 | 1 = GPIO, 0 = LED |
| p0_push_pull_o | output | 1 | Port 0 drive: 1 push-pull, 0 open drain |
| dim_range_o | output | 2 | Dimming range select |
| dim_lvl_o | output | 128 | Per-pin dimming level, 8 bits per pin |
| rd_in0_o | output | 1 | Port 0 input register fetched |
| rd_in1_o | output | 1 | Port 1 input register fetched |
| soft_rst_o | output | 1 | Software-reset pulse |

## Verification
A software-reset write reloads the output registers from the straps in the same edge where an ordinary write would store data. The bench provokes this by changing the straps between transfers, so the reload has to use the strap value present at that edge. The reload is judged by the output ports and by the new address that is acknowledged.

A burst write starting at FEh makes the pointer wrap in the middle of a transfer. The last byte of that burst must land in 02h while the bytes aimed at 00h and reserved addresses leave every output unchanged. The bench judges this by the output ports after the burst.

// File: rtl/pinctl_pkg.sv
package pinctl_pkg;
  localparam int PORT_W    = 8;
  localparam int NUM_PORTS = 2;
  localparam int PIN_W     = PORT_W * NUM_PORTS;
  localparam int DIM_W     = 8;
  localparam int NUM_DIM   = PIN_W;
  localparam int CNT_W     = 4;

  localparam logic [7:0] A_IN0    = 8'h00;
  localparam logic [7:0] A_OUT0   = 8'h02;
  localparam logic [7:0] A_DIR0   = 8'h04;
  localparam logic [7:0] A_MSK0   = 8'h06;
  localparam logic [7:0] A_ID     = 8'h10;
  localparam logic [7:0] A_CTL    = 8'h11;
  localparam logic [7:0] A_MODE0  = 8'h12;
  localparam logic [7:0] A_DIM0   = 8'h20;
  localparam logic [7:0] A_SRST   = 8'h7F;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_ADDR_ACK, S_PTR, S_PTR_ACK,
    S_WDAT, S_WDAT_ACK, S_RDAT, S_RACK
  } bus_st_e;

  // dimming slot -> pin index (port 0 = pins 0..7, port 1 = pins 8..15)
  function automatic int dim_pin(input int slot);
    if (slot < 4)       return slot + 8;
    else if (slot < 12) return slot - 4;
    else                return slot;
  endfunction
endpackage

// File: rtl/pinctl_sync.sv
module pinctl_sync #(
  parameter int           W       = 2,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pinctl_bus.sv
module pinctl_bus
  import pinctl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_s_i,
  input  logic       sda_s_i,
  input  logic [6:0] dev_addr_i,
  input  logic [7:0] rd_byte_i,
  output logic       sda_oe_o,
  output logic [7:0] ptr_o,
  output logic       wr_stb_o,
  output logic [7:0] wr_data_o,
  output logic       rd_load_o
);
  bus_st_e    st_q;
  logic       scl_q, sda_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0] rx_q, tx_q, ptr_q;
  logic       rw_q, mack_q, oe_q;

  logic scl_rise, scl_fall, start_c, stop_c, byte_in, addr_hit;

  assign scl_rise = scl_s_i & ~scl_q;
  assign scl_fall = ~scl_s_i & scl_q;
  assign start_c  = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_c   = scl_s_i & scl_q & ~sda_q & sda_s_i;
  assign byte_in  = (cnt_q == CNT_W'(8));
  assign addr_hit = (rx_q[7:1] == dev_addr_i);

  assign rd_load_o = scl_fall && !start_c && !stop_c &&
                     ((st_q == S_ADDR_ACK && rw_q) || (st_q == S_RACK && mack_q));
  assign wr_stb_o  = scl_fall && !start_c && !stop_c && st_q == S_WDAT && byte_in;
  assign wr_data_o = rx_q;
  assign ptr_o     = ptr_q;
  assign sda_oe_o  = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      ptr_q  <= '0;
      rw_q   <= 1'b0;
      mack_q <= 1'b0;
      oe_q   <= 1'b0;
    end else if (start_c) begin
      st_q  <= S_ADDR;
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else if (stop_c) begin
      st_q <= S_IDLE;
      oe_q <= 1'b0;
    end else begin
      if (scl_rise) begin
        unique case (st_q)
          S_ADDR, S_PTR, S_WDAT: begin
            rx_q  <= {rx_q[6:0], sda_s_i};
            cnt_q <= cnt_q + CNT_W'(1);
          end
          S_RDAT:  cnt_q  <= cnt_q + CNT_W'(1);
          S_RACK:  mack_q <= ~sda_s_i;
          default: ;
        endcase
      end
      if (scl_fall) begin
        unique case (st_q)
          S_ADDR: if (byte_in) begin
            if (addr_hit) begin
              oe_q <= 1'b1;
              rw_q <= rx_q[0];
              st_q <= S_ADDR_ACK;
            end else begin
              st_q <= S_IDLE;
            end
          end
          S_ADDR_ACK: begin
            cnt_q <= '0;
            if (rw_q) begin
              tx_q  <= rd_byte_i;
              oe_q  <= ~rd_byte_i[7];
              ptr_q <= ptr_q + 8'd1;
              st_q  <= S_RDAT;
            end else begin
              oe_q <= 1'b0;
              st_q <= S_PTR;
            end
          end
          S_PTR: if (byte_in) begin
            ptr_q <= rx_q;
            oe_q  <= 1'b1;
            st_q  <= S_PTR_ACK;
          end
          S_WDAT: if (byte_in) begin
            ptr_q <= ptr_q + 8'd1;
            oe_q  <= 1'b1;
            st_q  <= S_WDAT_ACK;
          end
          S_PTR_ACK, S_WDAT_ACK: begin
            oe_q  <= 1'b0;
            cnt_q <= '0;
            st_q  <= S_WDAT;
          end
          S_RDAT: begin
            if (byte_in) begin
              oe_q <= 1'b0;
              st_q <= S_RACK;
            end else begin
              tx_q <= {tx_q[6:0], 1'b0};
              oe_q <= ~tx_q[6];
            end
          end
          S_RACK: begin
            cnt_q <= '0;
            if (mack_q) begin
              tx_q  <= rd_byte_i;
              oe_q  <= ~rd_byte_i[7];
              ptr_q <= ptr_q + 8'd1;
              st_q  <= S_RDAT;
            end else begin
              st_q <= S_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pinctl_regs.sv
module pinctl_regs
  import pinctl_pkg::*;
#(
  parameter logic [7:0] ID_VAL = 8'h23
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [1:0]             strap_i,
  input  logic [PIN_W-1:0]       pin_lvl_i,
  input  logic                   wr_stb_i,
  input  logic [7:0]             wr_addr_i,
  input  logic [7:0]             wr_data_i,
  input  logic [7:0]             rd_addr_i,
  input  logic                   rd_load_i,
  output logic [7:0]             rd_byte_o,
  output logic [PIN_W-1:0]       out_val_o,
  output logic [PIN_W-1:0]       dir_in_o,
  output logic [PIN_W-1:0]       irq_mask_o,
  output logic [PIN_W-1:0]       led_gpio_o,
  output logic                   p0_pp_o,
  output logic [1:0]             dim_range_o,
  output logic [NUM_DIM*DIM_W-1:0] dim_lvl_o,
  output logic [NUM_PORTS-1:0]   rd_in_o,
  output logic                   soft_rst_o
);
  logic init_q, srst_q, do_srst, load_dflt;
  logic [PORT_W-1:0] dflt_out;
  logic       pp_q;
  logic [1:0] rng_q;
  logic [NUM_PORTS-1:0][PORT_W-1:0] out_a, dir_a, msk_a, mode_a;
  logic [NUM_PORTS-1:0] rd_in_q;

  assign do_srst   = wr_stb_i && wr_addr_i == A_SRST && wr_data_i == 8'h00;
  assign load_dflt = init_q | do_srst;
  assign dflt_out  = {{(PORT_W/2){strap_i[1]}}, {(PORT_W/2){strap_i[0]}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= 1'b1;
      srst_q <= 1'b0;
    end else begin
      init_q <= 1'b0;
      srst_q <= do_srst;
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [PORT_W-1:0] out_q, dir_q, msk_q, mode_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        out_q <= '0; dir_q <= '0; msk_q <= '0; mode_q <= '1;
      end else if (load_dflt) begin
        out_q <= dflt_out; dir_q <= '0; msk_q <= '0; mode_q <= '1;
      end else if (wr_stb_i) begin
        if (wr_addr_i == A_OUT0  + 8'(p)) out_q  <= wr_data_i;
        if (wr_addr_i == A_DIR0  + 8'(p)) dir_q  <= wr_data_i;
        if (wr_addr_i == A_MSK0  + 8'(p)) msk_q  <= wr_data_i;
        if (wr_addr_i == A_MODE0 + 8'(p)) mode_q <= wr_data_i;
      end
    end
    assign out_a[p]  = out_q;
    assign dir_a[p]  = dir_q;
    assign msk_a[p]  = msk_q;
    assign mode_a[p] = mode_q;
    assign out_val_o [p*PORT_W +: PORT_W] = out_q;
    assign dir_in_o  [p*PORT_W +: PORT_W] = dir_q;
    assign irq_mask_o[p*PORT_W +: PORT_W] = msk_q;
    assign led_gpio_o[p*PORT_W +: PORT_W] = mode_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rd_in_q[p] <= 1'b0;
      else         rd_in_q[p] <= rd_load_i && rd_addr_i == A_IN0 + 8'(p);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pp_q  <= 1'b0;
      rng_q <= '0;
    end else if (load_dflt) begin
      pp_q  <= 1'b0;
      rng_q <= '0;
    end else if (wr_stb_i && wr_addr_i == A_CTL) begin
      pp_q  <= wr_data_i[4];
      rng_q <= wr_data_i[1:0];
    end
  end

  for (genvar s = 0; s < NUM_DIM; s++) begin : g_dim
    localparam int PIN = dim_pin(s);
    logic [DIM_W-1:0] lvl_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        lvl_q <= '0;
      else if (load_dflt) lvl_q <= '0;
      else if (wr_stb_i && wr_addr_i == A_DIM0 + 8'(s)) lvl_q <= wr_data_i[DIM_W-1:0];
    end
    assign dim_lvl_o[PIN*DIM_W +: DIM_W] = lvl_q;
  end

  always_comb begin
    rd_byte_o = 8'h00;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (rd_addr_i == A_IN0   + 8'(p)) rd_byte_o = pin_lvl_i[p*PORT_W +: PORT_W];
      if (rd_addr_i == A_OUT0  + 8'(p)) rd_byte_o = out_a[p];
      if (rd_addr_i == A_DIR0  + 8'(p)) rd_byte_o = dir_a[p];
      if (rd_addr_i == A_MSK0  + 8'(p)) rd_byte_o = msk_a[p];
      if (rd_addr_i == A_MODE0 + 8'(p)) rd_byte_o = mode_a[p];
    end
    if (rd_addr_i == A_ID)  rd_byte_o = ID_VAL;
    if (rd_addr_i == A_CTL) rd_byte_o = {3'b000, pp_q, 2'b00, rng_q};
  end

  assign p0_pp_o     = pp_q;
  assign dim_range_o = rng_q;
  assign rd_in_o     = rd_in_q;
  assign soft_rst_o  = srst_q;
endmodule

// File: rtl/pinctl_i2c_slave.sv
module pinctl_i2c_slave
  import pinctl_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] ADDR_HI     = 5'b10110,
  parameter logic [7:0] ID_VAL      = 8'h23
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     scl_i,
  input  logic                     sda_i,
  output logic                     sda_oe_o,
  input  logic [1:0]               strap_i,
  input  logic [PIN_W-1:0]         pin_lvl_i,
  output logic [PIN_W-1:0]         out_val_o,
  output logic [PIN_W-1:0]         dir_in_o,
  output logic [PIN_W-1:0]         irq_mask_o,
  output logic [PIN_W-1:0]         led_gpio_o,
  output logic                     p0_push_pull_o,
  output logic [1:0]               dim_range_o,
  output logic [NUM_DIM*DIM_W-1:0] dim_lvl_o,
  output logic                     rd_in0_o,
  output logic                     rd_in1_o,
  output logic                     soft_rst_o
);
  logic [1:0] bus_s;
  logic [7:0] ptr, wr_data, rd_byte;
  logic       wr_stb, rd_load;
  logic [NUM_PORTS-1:0] rd_in;

  pinctl_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (bus_s)
  );

  pinctl_bus u_bus (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_s_i   (bus_s[1]),
    .sda_s_i   (bus_s[0]),
    .dev_addr_i({ADDR_HI, strap_i}),
    .rd_byte_i (rd_byte),
    .sda_oe_o  (sda_oe_o),
    .ptr_o     (ptr),
    .wr_stb_o  (wr_stb),
    .wr_data_o (wr_data),
    .rd_load_o (rd_load)
  );

  pinctl_regs #(.ID_VAL(ID_VAL)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .strap_i    (strap_i),
    .pin_lvl_i  (pin_lvl_i),
    .wr_stb_i   (wr_stb),
    .wr_addr_i  (ptr),
    .wr_data_i  (wr_data),
    .rd_addr_i  (ptr),
    .rd_load_i  (rd_load),
    .rd_byte_o  (rd_byte),
    .out_val_o  (out_val_o),
    .dir_in_o   (dir_in_o),
    .irq_mask_o (irq_mask_o),
    .led_gpio_o (led_gpio_o),
    .p0_pp_o    (p0_push_pull_o),
    .dim_range_o(dim_range_o),
    .dim_lvl_o  (dim_lvl_o),
    .rd_in_o    (rd_in),
    .soft_rst_o (soft_rst_o)
  );

  assign rd_in0_o = rd_in[0];
  assign rd_in1_o = rd_in[1];
endmodule

// File: rtl/pinctl_chk.sv
module pinctl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        scl_i,
  input logic        sda_oe_o,
  input logic [1:0]  strap_i,
  input logic [15:0] out_val_o,
  input logic [15:0] dir_in_o,
  input logic [15:0] irq_mask_o,
  input logic [15:0] led_gpio_o,
  input logic        p0_push_pull_o,
  input logic [1:0]  dim_range_o,
  input logic [127:0] dim_lvl_o,
  input logic        rd_in0_o,
  input logic        rd_in1_o,
  input logic        soft_rst_o
);
  // SDA is only changed by the slave while SCL is low
  assert_sda_change_scl_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i);

  assert_srst_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> !soft_rst_o);

  assert_srst_defaults_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |-> (dir_in_o == 16'h0 && irq_mask_o == 16'h0 && led_gpio_o == 16'hFFFF &&
                    !p0_push_pull_o && dim_range_o == 2'd0 && dim_lvl_o == '0));

  assert_srst_strap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |-> out_val_o == {2{{4{$past(strap_i[1])}}, {4{$past(strap_i[0])}}}});

  assert_rd_strobe_excl_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_in0_o && rd_in1_o));

  assert_rd0_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_in0_o |=> !rd_in0_o);

  assert_rd1_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_in1_o |=> !rd_in1_o);
endmodule

bind pinctl_i2c_slave pinctl_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .scl_i         (scl_i),
  .sda_oe_o      (sda_oe_o),
  .strap_i       (strap_i),
  .out_val_o     (out_val_o),
  .dir_in_o      (dir_in_o),
  .irq_mask_o    (irq_mask_o),
  .led_gpio_o    (led_gpio_o),
  .p0_push_pull_o(p0_push_pull_o),
  .dim_range_o   (dim_range_o),
  .dim_lvl_o     (dim_lvl_o),
  .rd_in0_o      (rd_in0_o),
  .rd_in1_o      (rd_in1_o),
  .soft_rst_o    (soft_rst_o)
);

// File: tb/sim_pinctl_i2c_slave.sv
module sim_pinctl_i2c_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] strap = 2'b00;
  logic [15:0] pins = 16'h0000;
  logic sda_line, sda_oe;
  logic [15:0] out_val, dir_in, irq_mask, led_gpio;
  logic p0_pp;
  logic [1:0] dim_rng;
  logic [127:0] dim_lvl;
  logic rd0, rd1, srst;

  int n_chk = 0, n_fail = 0;
  int rd0_cnt = 0, rd1_cnt = 0, srst_cnt = 0;
  logic [7:0] wbuf [0:31];
  logic [7:0] rbuf [0:31];
  logic oe_after_nack;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  pinctl_i2c_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .strap_i(strap), .pin_lvl_i(pins), .out_val_o(out_val), .dir_in_o(dir_in),
    .irq_mask_o(irq_mask), .led_gpio_o(led_gpio), .p0_push_pull_o(p0_pp),
    .dim_range_o(dim_rng), .dim_lvl_o(dim_lvl), .rd_in0_o(rd0), .rd_in1_o(rd1),
    .soft_rst_o(srst)
  );

  always @(posedge clk) begin
    if (rd0)  rd0_cnt  <= rd0_cnt + 1;
    if (rd1)  rd1_cnt  <= rd1_cnt + 1;
    if (srst) srst_cnt <= srst_cnt + 1;
  end

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  function automatic logic [7:0] dev_of(input logic [1:0] s);
    return {5'b10110, s, 1'b0};
  endfunction

  function automatic logic [15:0] strap_out(input logic [1:0] s);
    return {2{{4{s[1]}}, {4{s[0]}}}};
  endfunction

  task automatic i2c_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(); scl_m = 1'b0;
    end
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
    ack = ~sda_line;
    scl_m = 1'b0; wq();
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic mack);
    b = '0;
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wq(); scl_m = 1'b1; wq();
      b = {b[6:0], sda_line};
      scl_m = 1'b0;
    end
    sda_m = ~mack; wq(); scl_m = 1'b1; wq(); scl_m = 1'b0; wq();
    sda_m = 1'b1;
  endtask

  task automatic write_burst(input logic [7:0] ptr, input int n, output logic all_ack);
    logic a;
    all_ack = 1'b1;
    i2c_start();
    send_byte(dev_of(strap), a); all_ack &= a;
    send_byte(ptr, a);           all_ack &= a;
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], a); all_ack &= a;
    end
    i2c_stop();
  endtask

  task automatic write1(input logic [7:0] ptr, input logic [7:0] d);
    logic a;
    wbuf[0] = d;
    write_burst(ptr, 1, a);
    check("R1 own address acked", a, 1'b1);
  endtask

  task automatic read_burst(input logic [7:0] ptr, input int n);
    logic a;
    i2c_start();
    send_byte(dev_of(strap), a);
    send_byte(ptr, a);
    i2c_start();
    send_byte(dev_of(strap) | 8'h01, a);
    for (int k = 0; k < n; k++) recv_byte(rbuf[k], k < n - 1);
    oe_after_nack = sda_oe;
    i2c_stop();
  endtask

  task automatic do_reset(input logic [1:0] s);
    rst_n = 1'b0; strap = s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic a;
    logic [15:0] snap;
    logic [127:0] exp_dim;
    int c0, c1, cs;

    // reset state for every strap setting (R5, R6, R8, R9, R10)
    for (int s = 0; s < 4; s++) begin
      do_reset(2'(s));
      check("R5 reset out_val", out_val, strap_out(2'(s)));
      check("R6 reset dir", dir_in, 16'h0);
      check("R6 reset mask", irq_mask, 16'h0);
      check("R9 reset mode", led_gpio, 16'hFFFF);
      check("R8 reset ctl", {p0_pp, dim_rng}, 3'b000);
      check("R10 reset dim", dim_lvl, 128'h0);
      write1(8'h02, 8'h3C);
      check("R1 strap address write", out_val[7:0], 8'h3C);
    end

    // address sweep (R1)
    do_reset(2'b10);
    snap = out_val;
    for (int ad = 0; ad < 128; ad++) begin
      i2c_start();
      send_byte({7'(ad), 1'b0}, a);
      i2c_stop();
      check("R1 address sweep ack", a, (7'(ad) == 7'b1011010));
    end
    i2c_start();
    send_byte(8'h00, a);
    check("R1 general call nack", a, 1'b0);
    send_byte(8'h02, a);
    send_byte(8'hAA, a);
    i2c_stop();
    check("R1 foreign transfer ignored", out_val, snap);

    // burst write and burst read (R2, R3, R6)
    for (int k = 0; k < 6; k++) wbuf[k] = 8'(8'h11 * (k + 1));
    write_burst(8'h02, 6, a);
    check("R2 burst acked", a, 1'b1);
    check("R2 out_val", out_val, 16'h2211);
    check("R6 dir_in", dir_in, 16'h4433);
    check("R6 irq_mask", irq_mask, 16'h6655);
    read_burst(8'h02, 6);
    for (int k = 0; k < 6; k++) check("R3 burst readback", rbuf[k], 8'(8'h11 * (k + 1)));
    check("R3 sda released after nack", oe_after_nack, 1'b0);

    // input registers and read strobes (R4, R12)
    pins = 16'hA53C;
    c0 = rd0_cnt; c1 = rd1_cnt;
    read_burst(8'h00, 2);
    check("R4 input port0", rbuf[0], 8'h3C);
    check("R4 input port1", rbuf[1], 8'hA5);
    check("R12 rd0 strobe count", 32'(rd0_cnt - c0), 32'd1);
    check("R12 rd1 strobe count", 32'(rd1_cnt - c1), 32'd1);
    c0 = rd0_cnt; c1 = rd1_cnt;
    read_burst(8'h01, 1);
    check("R12 rd1 only", {32'(rd0_cnt - c0), 32'(rd1_cnt - c1)}, {32'd0, 32'd1});
    snap = out_val;
    write1(8'h00, 8'hFF);
    pins = 16'h5AC3;
    read_burst(8'h00, 1);
    check("R4 write ignored, live level", rbuf[0], 8'hC3);
    check("R4 write leaves outputs", out_val, snap);

    // ID (R7)
    write1(8'h10, 8'h55);
    read_burst(8'h10, 1);
    check("R7 id value", rbuf[0], 8'h23);

    // global control (R8)
    write1(8'h11, 8'hFF);
    check("R8 ctl ports", {p0_pp, dim_rng}, 3'b111);
    read_burst(8'h11, 1);
    check("R8 ctl readback", rbuf[0], 8'h13);
    write1(8'h11, 8'h12);
    check("R8 ctl ports 2", {p0_pp, dim_rng}, 3'b110);

    // mode (R9)
    wbuf[0] = 8'h5A; wbuf[1] = 8'hC3;
    write_burst(8'h12, 2, a);
    check("R9 led_gpio", led_gpio, 16'hC35A);
    read_burst(8'h12, 2);
    check("R9 readback", {rbuf[1], rbuf[0]}, 16'hC35A);

    // dimming slots (R10)
    exp_dim = '0;
    for (int k = 0; k < 16; k++) begin
      int pn;
      wbuf[k] = 8'(k * 13 + 7);
      pn = (k < 4) ? k + 8 : (k < 12 ? k - 4 : k);
      exp_dim[pn*8 +: 8] = 8'(k * 13 + 7);
    end
    write_burst(8'h20, 16, a);
    check("R10 dim mapping", dim_lvl, exp_dim);
    read_burst(8'h20, 1);
    check("R10 dim reads zero", rbuf[0], 8'h00);
    read_burst(8'h08, 1);
    check("R10 reserved reads zero", rbuf[0], 8'h00);
    read_burst(8'h7F, 1);
    check("R10 reset reg reads zero", rbuf[0], 8'h00);

    // pointer wrap (R2)
    snap = out_val;
    for (int k = 0; k < 5; k++) wbuf[k] = 8'h77;
    write_burst(8'hFE, 5, a);
    check("R2 wrap lands in 02h", out_val, {snap[15:8], 8'h77});
    check("R2 wrap dir untouched", dir_in, 16'h4433);

    // software reset (R11, R5)
    cs = srst_cnt;
    write1(8'h7F, 8'h01);
    check("R11 nonzero write no pulse", 32'(srst_cnt - cs), 32'd0);
    check("R11 nonzero write no effect", dir_in, 16'h4433);
    strap = 2'b01;
    write1(8'h7F, 8'h00);
    check("R11 pulse count", 32'(srst_cnt - cs), 32'd1);
    check("R5 strap reload", out_val, strap_out(2'b01));
    check("R11 dir default", dir_in, 16'h0);
    check("R11 mask default", irq_mask, 16'h0);
    check("R11 mode default", led_gpio, 16'hFFFF);
    check("R11 ctl default", {p0_pp, dim_rng}, 3'b000);
    check("R11 dim default", dim_lvl, 128'h0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule